// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch or a conditional flag-to-register write should take effect. It receives a 4-bit condition selector and a processor status word. From the status word it pulls five single-bit flags: zero, sign, overflow, carry and saturation. It returns one bit that says whether the selected condition holds.

The same decision bit feeds two consumers. Branch logic uses it together with a target address, which the block forms by adding a sign-extended 9-bit displacement to the current program counter. The conditional-set operation uses it as a 32-bit value that is either 0 or 1.

The block is combinational by default. A parameter adds one output register stage, cleared by an active-low reset, for designs where the evaluation sits on a timing-critical path. Fetch, pipeline control and flag updates stay with the surrounding logic.

Top module: `brcond_unit`

## Requirements
- R1: Selector codes 0, 1, 2, 3 and 4 make taken_o equal to OV, CY, Z, (CY or Z) and S respectively.
- R2: Selector code 5 makes taken_o equal to 1 whatever the flags are.
- R3: Selector code 6 makes taken_o equal to S xor OV. Selector code 7 makes taken_o equal to Z or (S xor OV).
- R4: Selector codes 8 to 12 give the inverse of codes 0 to 4 respectively.
- R5: Selector code 13 makes taken_o equal to the saturation flag.
- R6: Selector codes 14 and 15 give the inverse of codes 6 and 7 respectively.
- R7: target_o equals pc_i plus operand_i[8:0] sign-extended to 32 bits, with wrap-around modulo 2^32. operand_i[31:9] has no effect.
- R8: setf_o equals 1 when taken_o is 1 and 0 otherwise. Bits 31:1 of setf_o are always zero.
- R9: The flags are read from status_i at these bit positions: Z at bit 0, S at bit 1, OV at bit 2, CY at bit 3 and SAT at bit 4. status_i[31:5] has no effect.
- R10: When REG_OUT is 1, the outputs show the result for the inputs applied one clock earlier. While rst_n is 0, taken_o, target_o and setf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register stage |
| rst_n | input | 1 | Active-low reset for the optional output register stage |
| cond_i | input | 4 | Condition selector |
| status_i | input | 32 | Processor status word holding the flags |
| pc_i | input | 32 | Current program counter |
| operand_i | input | 32 | Operand; its low 9 bits are the branch displacement |
| taken_o | output | 1 | Condition holds |
| target_o | output | 32 | Branch target address |
| setf_o | output | 32 | Condition result zero-extended to 32 bits |

## Verification
The bench applies every selector code with all 32 combinations of the five flags. This shows whether each code tests the intended flag and the intended polarity. It also catches a swapped flag position or a code 13 that decodes as the inverse of code 5. In these vectors the unused status bits are loaded with pseudo-random values, so any dependence on them shows up as a miscompare.

Each of the 512 displacement values is added to three program counters: zero, a mid-range value and a value close to the top of the address space. This separates correct sign extension and wrap-around from zero extension or a wrong sign bit. The upper operand bits carry noise throughout. The bench runs with the output register enabled, so it also checks the one-cycle latency and the cleared state during reset.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

   // decoded flag bundle
   typedef struct packed {
      logic z;
      logic s;
      logic ov;
      logic cy;
      logic sat;
   } flags_t;

   // selector codes whose numbering the decoder relies on
   localparam logic [3:0] SEL_ALWAYS = 4'd5;
   localparam logic [3:0] SEL_SAT    = 4'd13;
   localparam int         SEL_W      = 4;
   localparam int         BASE_N     = 8;

endpackage

// File: rtl/brcond_flag_pick.sv
module brcond_flag_pick
   import brcond_pkg::*;
#(
   parameter int STAT_W  = 32,
   parameter int Z_POS   = 0,
   parameter int S_POS   = 1,
   parameter int OV_POS  = 2,
   parameter int CY_POS  = 3,
   parameter int SAT_POS = 4
) (
   input  logic [STAT_W-1:0] status_i,
   output flags_t            flags_o
);

   generate
      if (Z_POS >= STAT_W || S_POS >= STAT_W || OV_POS >= STAT_W ||
          CY_POS >= STAT_W || SAT_POS >= STAT_W) begin : g_bad_pos
         $error("brcond_flag_pick: flag position outside status word");
      end
   endgenerate

   always_comb begin
      flags_o.z   = status_i[Z_POS];
      flags_o.s   = status_i[S_POS];
      flags_o.ov  = status_i[OV_POS];
      flags_o.cy  = status_i[CY_POS];
      flags_o.sat = status_i[SAT_POS];
   end

endmodule

// File: rtl/brcond_decide.sv
module brcond_decide
   import brcond_pkg::*;
(
   input  logic [SEL_W-1:0] cond_i,
   input  flags_t           flags_i,
   output logic             hold_o
);

   logic [BASE_N-1:0] base;
   logic              lt;
   logic              picked;

   // base conditions for the lower half of the code space
   always_comb begin
      lt      = flags_i.s ^ flags_i.ov;
      base[0] = flags_i.ov;
      base[1] = flags_i.cy;
      base[2] = flags_i.z;
      base[3] = flags_i.cy | flags_i.z;
      base[4] = flags_i.s;
      base[5] = 1'b1;
      base[6] = lt;
      base[7] = flags_i.z | lt;
   end

   // upper half inverts the base, except the saturation slot
   always_comb begin
      picked = base[cond_i[SEL_W-2:0]];
      if (cond_i == SEL_SAT) begin
         hold_o = flags_i.sat;
      end else if (cond_i[SEL_W-1]) begin
         hold_o = ~picked;
      end else begin
         hold_o = picked;
      end
   end

endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
   parameter int ADDR_W = 32,
   parameter int OPND_W = 32,
   parameter int DISP_W = 9
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [OPND_W-1:0] operand_i,
   output logic [ADDR_W-1:0] target_o
);

   localparam int EXT_W = ADDR_W - DISP_W;

   generate
      if (DISP_W > OPND_W || DISP_W >= ADDR_W || DISP_W < 2) begin : g_bad_w
         $error("brcond_target: displacement width out of range");
      end
   endgenerate

   logic [DISP_W-1:0] disp;
   logic [ADDR_W-1:0] disp_ext;
   logic [OPND_W-1:0] unused_opnd;

   assign disp        = operand_i[DISP_W-1:0];
   assign unused_opnd = operand_i;
   assign disp_ext    = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign target_o    = pc_i + disp_ext;

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
   import brcond_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OPND_W  = 32,
   parameter int DATA_W  = 32,
   parameter int STAT_W  = 32,
   parameter int DISP_W  = 9,
   parameter int Z_POS   = 0,
   parameter int S_POS   = 1,
   parameter int OV_POS  = 2,
   parameter int CY_POS  = 3,
   parameter int SAT_POS = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cond_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [OPND_W-1:0] operand_i,
   output logic              taken_o,
   output logic [ADDR_W-1:0] target_o,
   output logic [DATA_W-1:0] setf_o
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("brcond_unit: DATA_W must be at least 1");
      end
   endgenerate

   flags_t              flags;
   logic                hold;
   logic [ADDR_W-1:0]   tgt;
   logic [STAT_W-1:0]   unused_status;

   assign unused_status = status_i;

   brcond_flag_pick #(
      .STAT_W (STAT_W),
      .Z_POS  (Z_POS),
      .S_POS  (S_POS),
      .OV_POS (OV_POS),
      .CY_POS (CY_POS),
      .SAT_POS(SAT_POS)
   ) u_pick (
      .status_i(status_i),
      .flags_o (flags)
   );

   brcond_decide u_decide (
      .cond_i (cond_i),
      .flags_i(flags),
      .hold_o (hold)
   );

   brcond_target #(
      .ADDR_W(ADDR_W),
      .OPND_W(OPND_W),
      .DISP_W(DISP_W)
   ) u_target (
      .pc_i     (pc_i),
      .operand_i(operand_i),
      .target_o (tgt)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic              taken_q;
         logic [ADDR_W-1:0] target_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               taken_q  <= 1'b0;
               target_q <= '0;
            end else begin
               taken_q  <= hold;
               target_q <= tgt;
            end
         end
         assign taken_o  = taken_q;
         assign target_o = target_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign taken_o    = hold;
         assign target_o   = tgt;
      end
   endgenerate

   assign setf_o = {{(DATA_W-1){1'b0}}, taken_o};

endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
   parameter int ADDR_W  = 32,
   parameter int OPND_W  = 32,
   parameter int DATA_W  = 32,
   parameter int STAT_W  = 32,
   parameter int DISP_W  = 9,
   parameter int S_POS   = 1,
   parameter int OV_POS  = 2,
   parameter int SAT_POS = 4,
   parameter bit REG_OUT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        cond_i,
   input logic [STAT_W-1:0] status_i,
   input logic [ADDR_W-1:0] pc_i,
   input logic [OPND_W-1:0] operand_i,
   input logic              taken_o,
   input logic [ADDR_W-1:0] target_o,
   input logic [DATA_W-1:0] setf_o
);

   logic [3:0]        d_cond;
   logic [STAT_W-1:0] d_stat;
   logic [ADDR_W-1:0] d_pc;
   logic [OPND_W-1:0] d_opnd;
   logic              d_ok;

   generate
      if (REG_OUT) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_cond <= '0;
               d_stat <= '0;
               d_pc   <= '0;
               d_opnd <= '0;
               d_ok   <= 1'b0;
            end else begin
               d_cond <= cond_i;
               d_stat <= status_i;
               d_pc   <= pc_i;
               d_opnd <= operand_i;
               d_ok   <= 1'b1;
            end
         end
      end else begin : g_nodly
         assign d_cond = cond_i;
         assign d_stat = status_i;
         assign d_pc   = pc_i;
         assign d_opnd = operand_i;
         assign d_ok   = 1'b1;
      end
   endgenerate

   assert_always_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_ok && d_cond == 4'd5) |-> taken_o);

   assert_lt_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (d_ok && d_cond == 4'd6 && d_stat[S_POS] == d_stat[OV_POS]) |-> !taken_o);

   assert_sat_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_ok && d_cond == 4'd13 && !d_stat[SAT_POS]) |-> !taken_o);

   assert_sat_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_ok && d_cond == 4'd13 && d_stat[SAT_POS]) |-> taken_o);

   assert_zero_disp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_ok && d_opnd[DISP_W-1:0] == '0) |-> (target_o == d_pc));

   assert_setf_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (setf_o[0] == taken_o) && (setf_o[DATA_W-1:1] == '0));

   assert_reset_clear_R10: assert property (@(posedge clk)
      (REG_OUT && !rst_n) |-> (!taken_o && target_o == '0));

endmodule

bind brcond_unit brcond_unit_chk #(
   .ADDR_W (ADDR_W),
   .OPND_W (OPND_W),
   .DATA_W (DATA_W),
   .STAT_W (STAT_W),
   .DISP_W (DISP_W),
   .S_POS  (S_POS),
   .OV_POS (OV_POS),
   .SAT_POS(SAT_POS),
   .REG_OUT(REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cond_i   (cond_i),
   .status_i (status_i),
   .pc_i     (pc_i),
   .operand_i(operand_i),
   .taken_o  (taken_o),
   .target_o (target_o),
   .setf_o   (setf_o)
);

// File: tb/brcond_unit_tb.sv
`timescale 1ns/1ps
module brcond_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cond_i = '0;
   logic [31:0] status_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] operand_i = '0;
   logic        taken_o;
   logic [31:0] target_o;
   logic [31:0] setf_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   brcond_unit #(.REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .status_i(status_i),
      .pc_i(pc_i), .operand_i(operand_i), .taken_o(taken_o),
      .target_o(target_o), .setf_o(setf_o)
   );

   // flags: bit0 Z, bit1 S, bit2 OV, bit3 CY, bit4 SAT
   function automatic bit exp_cond(input int code, input logic [4:0] f);
      bit z, s, ov, cy, sat, lt;
      z = f[0]; s = f[1]; ov = f[2]; cy = f[3]; sat = f[4];
      lt = s ^ ov;
      case (code)
         0: return ov;
         1: return cy;
         2: return z;
         3: return cy | z;
         4: return s;
         5: return 1'b1;
         6: return lt;
         7: return z | lt;
         8: return !ov;
         9: return !cy;
         10: return !z;
         11: return !(cy | z);
         12: return !s;
         13: return sat;
         14: return !lt;
         default: return !(z | lt);
      endcase
   endfunction

   function automatic string req_of(input int code);
      if (code <= 4) return "R1";
      if (code == 5) return "R2";
      if (code <= 7) return "R3";
      if (code <= 12) return "R4";
      if (code == 13) return "R5";
      return "R6";
   endfunction

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] c, input logic [31:0] st,
                        input logic [31:0] pc, input logic [31:0] op);
      @(negedge clk);
      cond_i = c; status_i = st; pc_i = pc; operand_i = op;
      @(posedge clk);
      #1;
   endtask

   initial begin
      logic [31:0] pcs [3];
      logic [31:0] noise;
      logic [31:0] exp_t;
      pcs[0] = 32'h0000_0000;
      pcs[1] = 32'h4000_1230;
      pcs[2] = 32'hFFFF_FF80;

      // R10: reset state with a condition that would be true
      cond_i = 4'd5;
      repeat (3) @(posedge clk);
      #1;
      check32("R10 reset taken", {31'b0, taken_o}, 32'd0);
      check32("R10 reset target", target_o, 32'd0);
      check32("R10 reset setf", setf_o, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1-class sweep: every code with every flag combination, R9 noise above
      for (int code = 0; code < 16; code++) begin
         for (int f = 0; f < 32; f++) begin
            noise = $random;
            apply(code[3:0], {noise[31:5], f[4:0]}, 32'h100, 32'h0);
            check32({req_of(code), " cond/R9 flags"}, {31'b0, taken_o},
                    {31'b0, exp_cond(code, f[4:0])});
            check32("R8 setf", setf_o, {31'b0, exp_cond(code, f[4:0])});
         end
      end

      // R7: every displacement, three program counters, noisy upper operand
      for (int p = 0; p < 3; p++) begin
         for (int d = 0; d < 512; d++) begin
            noise = $random;
            apply(4'd5, 32'h0, pcs[p], {noise[31:9], d[8:0]});
            exp_t = pcs[p] + ((d >= 256) ? (32'(d) - 32'd512) : 32'(d));
            check32("R7 target", target_o, exp_t);
         end
      end

      // R10: latency -- output reflects the previous cycle's inputs
      apply(4'd2, 32'h1, 32'h0, 32'h0);
      @(negedge clk);
      cond_i = 4'd10;
      #1;
      check32("R10 latency hold", {31'b0, taken_o}, 32'd1);
      @(posedge clk);
      #1;
      check32("R10 latency update", {31'b0, taken_o}, 32'd0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule